// File: doc/BRIEF.md
# Ping-pong transfer FIFO pair

The block sits between a 16-bit host port and a byte-wide bus handshake engine. It holds two byte FIFOs of equal depth. At any moment one of them faces the host and the other faces the bus. A flip command swaps the two roles, so the host can fill or empty one buffer while the bus side drains or fills the other.

Before each bus transfer the host stages a 16-bit byte count, one byte at a time, and then pulses a start strobe. The bus side then moves exactly that many bytes through its FIFO and raises the completion flag. The direction comes from the phase input. In the device-to-bus phase the bus-side FIFO is drained toward the engine. In the bus-to-device phase the engine's bytes are stored in it. Host words carry two bytes, and the low byte comes first.

Top module: `pingpong_xfer_fifo`

## Requirements
- R1: After reset both FIFOs are empty, `sel_o` is 0 (FIFO 0 faces the host), `done_o` is 1, and `ovf_o`, `unf_o` and `arm_err_o` are 0.
- R2: A `flip_i` pulse inverts `sel_o`. The FIFO that faced the bus, with its contents, then faces the host, and the other FIFO takes the bus role.
- R3: A host write pushes `host_wdata_i[7:0]` and then `host_wdata_i[15:8]`. If fewer than two bytes are free, the write is dropped and the sticky `ovf_o` is set.
- R4: `host_rdata_o` shows the oldest byte in bits [7:0] and the next byte in [15:8], and a read pops both. With one byte left, [15:8] reads 0 and only that byte is popped. A read of an empty FIFO is dropped and sets the sticky `unf_o`.
- R5: The count is {high byte, low byte}, staged by `cnt_hi_wr_i`/`cnt_lo_wr_i` from `cnt_byte_i`. `cnt_set_i` starts the transfer. `done_o` is 0 while it runs and returns to 1 once exactly that many bytes have crossed the bus side.
- R6: With `phase_in_i`=1, the bus-side bytes are offered on `bus_tx_data_o` in write order. `bus_tx_valid_o` is high only while a transfer runs and the FIFO is not empty. Each `bus_tx_ack_i` while valid consumes one byte.
- R7: With `phase_in_i`=0, `bus_rx_ready_o` is high only while a transfer runs and the bus-side FIFO is not full. Each `bus_rx_valid_i` while ready stores `bus_rx_data_i`.
- R8: A `cnt_set_i` while a transfer runs is ignored and sets the sticky `arm_err_o`. A start with count 0 leaves `done_o` at 1.
- R9: When a device-to-bus transfer completes, any bytes left in the bus-side FIFO (the pad byte of an odd count) are discarded.
- R10: A full flag is 1 when its FIFO holds DEPTH bytes and an empty flag is 1 when it holds none. `host_*` flags describe the host-facing FIFO and `alt_*` flags describe the other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host word write |
| host_wdata_i | input | 16 | Host write word, low byte first |
| host_rd_i | input | 1 | Host word read (pop) |
| host_rdata_o | output | 16 | Head word of the host-facing FIFO |
| flip_i | input | 1 | Swap FIFO roles |
| host_empty_o | output | 1 | Host-facing FIFO empty |
| host_full_o | output | 1 | Host-facing FIFO full |
| alt_empty_o | output | 1 | Bus-facing FIFO empty |
| alt_full_o | output | 1 | Bus-facing FIFO full |
| sel_o | output | 1 | Index of the host-facing FIFO |
| ovf_o | output | 1 | Sticky dropped-write flag |
| unf_o | output | 1 | Sticky dropped-read flag |
| cnt_hi_wr_i | input | 1 | Stage count high byte |
| cnt_lo_wr_i | input | 1 | Stage count low byte |
| cnt_byte_i | input | 8 | Count byte value |
| cnt_set_i | input | 1 | Start bus transfer |
| done_o | output | 1 | No transfer running |
| arm_err_o | output | 1 | Sticky start-while-busy flag |
| phase_in_i | input | 1 | 1: device to bus, 0: bus to device |
| bus_tx_valid_o | output | 1 | Byte offered to the engine |
| bus_tx_data_o | output | 8 | Offered byte |
| bus_tx_ack_i | input | 1 | Engine consumed the byte |
| bus_rx_valid_i | input | 1 | Engine delivers a byte |
| bus_rx_data_i | input | 8 | Delivered byte |
| bus_rx_ready_o | output | 1 | Block can take a byte |

## Verification
The bench builds the block with DEPTH=8, so four host words fill a FIFO. This makes the full flag, the dropped fifth write and the overflow flag reachable within a few cycles. A 7-byte device-to-bus transfer from that full buffer exercises the odd-count path, and its discarded pad byte must leave the alternate FIFO empty. A 5-byte receive ends with a half-filled final read word and then an underflowing read.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ppf_byte_fifo.sv
module ppf_byte_fifo
  import pp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [1:0]        push_n_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        pop_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CW-1:0]     level_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  byte_t         mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_n_i != 2'd0) mem_q[wr_q] <= wdata_i[BYTE_W-1:0];
    if (push_n_i == 2'd2) mem_q[wr_q + AW'(1)] <= wdata_i[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push_n_i);
      rd_q  <= rd_q + AW'(pop_n_i);
      lvl_q <= lvl_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign rdata_o = {mem_q[rd_q + AW'(1)], mem_q[rd_q]};
  assign level_o = lvl_q;
endmodule

// File: rtl/ppf_xfer_count.sv
module ppf_xfer_count
  import pp_fifo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hi_wr_i,
  input  logic        lo_wr_i,
  input  byte_t       byte_i,
  input  logic        set_i,
  input  logic        beat_i,
  output logic        busy_o,
  output logic        last_o,
  output logic        err_o
);
  logic [CNT_W-1:0] stage_q, rem_q;
  logic             busy_q, err_q;

  assign last_o = busy_q && beat_i && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (hi_wr_i) stage_q[CNT_W-1:BYTE_W] <= byte_i;
      if (lo_wr_i) stage_q[BYTE_W-1:0]     <= byte_i;
      if (set_i && busy_q) err_q <= 1'b1;
      if (set_i && !busy_q && stage_q != '0) begin
        busy_q <= 1'b1;
        rem_q  <= stage_q;
      end
      if (busy_q && beat_i) begin
        rem_q <= rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pingpong_xfer_fifo.sv
module pingpong_xfer_fifo
  import pp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_wr_i,
  input  logic [15:0] host_wdata_i,
  input  logic        host_rd_i,
  output logic [15:0] host_rdata_o,
  input  logic        flip_i,
  output logic        host_empty_o,
  output logic        host_full_o,
  output logic        alt_empty_o,
  output logic        alt_full_o,
  output logic        sel_o,
  output logic        ovf_o,
  output logic        unf_o,
  input  logic        cnt_hi_wr_i,
  input  logic        cnt_lo_wr_i,
  input  logic [7:0]  cnt_byte_i,
  input  logic        cnt_set_i,
  output logic        done_o,
  output logic        arm_err_o,
  input  logic        phase_in_i,
  output logic        bus_tx_valid_o,
  output logic [7:0]  bus_tx_data_o,
  input  logic        bus_tx_ack_i,
  input  logic        bus_rx_valid_i,
  input  logic [7:0]  bus_rx_data_i,
  output logic        bus_rx_ready_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic              sel_q, ovf_q, unf_q;
  logic [CW-1:0]     lvl   [2];
  logic [WORD_W-1:0] head  [2];
  logic [CW-1:0]     host_lvl, bus_lvl;
  logic              wr_ok, busy, last, tx_pop, rx_push, clr_bus;
  logic [1:0]        host_pop_n;

  assign host_lvl = lvl[sel_q];
  assign bus_lvl  = lvl[~sel_q];

  assign wr_ok      = host_wr_i && ((CW'(DEPTH) - host_lvl) >= CW'(2));
  assign host_pop_n = !host_rd_i ? 2'd0 :
                      (host_lvl >= CW'(2)) ? 2'd2 :
                      (host_lvl == CW'(1)) ? 2'd1 : 2'd0;

  always_comb begin
    if (host_lvl == '0)             host_rdata_o = '0;
    else if (host_lvl == CW'(1))    host_rdata_o = {8'h00, head[sel_q][7:0]};
    else                            host_rdata_o = head[sel_q];
  end

  assign bus_tx_valid_o = busy && phase_in_i && (bus_lvl != '0);
  assign bus_tx_data_o  = head[~sel_q][7:0];
  assign bus_rx_ready_o = busy && !phase_in_i && (bus_lvl != CW'(DEPTH));
  assign tx_pop         = bus_tx_valid_o && bus_tx_ack_i;
  assign rx_push        = bus_rx_ready_o && bus_rx_valid_i;
  assign clr_bus        = last && phase_in_i;   // drop pad byte of odd send

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic       own_host;
    logic [1:0] push_n, pop_n;
    logic [15:0] wdata;
    assign own_host = (sel_q == 1'(g));
    assign push_n   = own_host ? (wr_ok ? 2'd2 : 2'd0) : (rx_push ? 2'd1 : 2'd0);
    assign pop_n    = own_host ? host_pop_n : (tx_pop ? 2'd1 : 2'd0);
    assign wdata    = own_host ? host_wdata_i : {8'h00, bus_rx_data_i};

    ppf_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (!own_host && clr_bus),
      .push_n_i (push_n),
      .wdata_i  (wdata),
      .pop_n_i  (pop_n),
      .rdata_o  (head[g]),
      .level_o  (lvl[g])
    );
  end

  ppf_xfer_count u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_wr_i (cnt_hi_wr_i),
    .lo_wr_i (cnt_lo_wr_i),
    .byte_i  (cnt_byte_i),
    .set_i   (cnt_set_i),
    .beat_i  (tx_pop || rx_push),
    .busy_o  (busy),
    .last_o  (last),
    .err_o   (arm_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (flip_i) sel_q <= ~sel_q;
      if (host_wr_i && !wr_ok) ovf_q <= 1'b1;
      if (host_rd_i && host_lvl == '0) unf_q <= 1'b1;
    end
  end

  assign sel_o        = sel_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
  assign done_o       = !busy;
  assign host_empty_o = (host_lvl == '0);
  assign host_full_o  = (host_lvl == CW'(DEPTH));
  assign alt_empty_o  = (bus_lvl == '0);
  assign alt_full_o   = (bus_lvl == CW'(DEPTH));
endmodule

// File: rtl/ppf_checker.sv
module ppf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic flip_i,
  input logic sel_o,
  input logic host_wr_i,
  input logic host_empty_o,
  input logic host_full_o,
  input logic ovf_o,
  input logic unf_o,
  input logic cnt_set_i,
  input logic done_o,
  input logic arm_err_o,
  input logic phase_in_i,
  input logic bus_tx_valid_o,
  input logic bus_rx_ready_o
);
  p_flip_swap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_i |=> sel_o != $past(sel_o));
  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flip_i |=> $stable(sel_o));
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_ovf_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(host_wr_i));
  p_unf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  p_unf_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> $past(host_empty_o));
  p_done_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(cnt_set_i));
  p_tx_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_tx_valid_o |-> !done_o && phase_in_i);
  p_rx_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rx_ready_o |-> !done_o && !phase_in_i);
  p_arm_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_set_i && !done_o) |=> arm_err_o);
  p_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_full_o && host_empty_o));
endmodule

bind pingpong_xfer_fifo ppf_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flip_i         (flip_i),
  .sel_o          (sel_o),
  .host_wr_i      (host_wr_i),
  .host_empty_o   (host_empty_o),
  .host_full_o    (host_full_o),
  .ovf_o          (ovf_o),
  .unf_o          (unf_o),
  .cnt_set_i      (cnt_set_i),
  .done_o         (done_o),
  .arm_err_o      (arm_err_o),
  .phase_in_i     (phase_in_i),
  .bus_tx_valid_o (bus_tx_valid_o),
  .bus_rx_ready_o (bus_rx_ready_o)
);

// File: tb/pingpong_xfer_fifo_bench.sv
module pingpong_xfer_fifo_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_wr = 0, host_rd = 0, flip = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_empty, host_full, alt_empty, alt_full, sel, ovf, unf;
  logic cnt_hi_wr = 0, cnt_lo_wr = 0, cnt_set = 0;
  logic [7:0] cnt_byte = '0;
  logic done, arm_err;
  logic phase_in = 0;
  logic tx_valid, tx_ack = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;

  int total = 0, bad = 0, tx_seen = 0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  pingpong_xfer_fifo #(.DEPTH(8)) u_pingpong_xfer_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata), .flip_i(flip),
    .host_empty_o(host_empty), .host_full_o(host_full),
    .alt_empty_o(alt_empty), .alt_full_o(alt_full), .sel_o(sel),
    .ovf_o(ovf), .unf_o(unf),
    .cnt_hi_wr_i(cnt_hi_wr), .cnt_lo_wr_i(cnt_lo_wr), .cnt_byte_i(cnt_byte),
    .cnt_set_i(cnt_set), .done_o(done), .arm_err_o(arm_err),
    .phase_in_i(phase_in),
    .bus_tx_valid_o(tx_valid), .bus_tx_data_o(tx_data), .bus_tx_ack_i(tx_ack),
    .bus_rx_valid_i(rx_valid), .bus_rx_data_i(rx_data), .bus_rx_ready_o(rx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: host write, expected bytes queued low first
  task automatic host_write(input logic [15:0] w, input bit expect_bus);
    host_wr = 1; host_wdata = w;
    @(negedge clk);
    host_wr = 0;
    if (expect_bus) begin
      exp_q.push_back(w[7:0]);
      exp_q.push_back(w[15:8]);
    end
  endtask

  task automatic host_read();
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic pulse_flip();
    flip = 1;
    @(negedge clk);
    flip = 0;
  endtask

  task automatic pulse_set();
    cnt_set = 1;
    @(negedge clk);
    cnt_set = 0;
  endtask

  task automatic load_count(input logic [15:0] c);
    cnt_hi_wr = 1; cnt_byte = c[15:8];
    @(negedge clk);
    cnt_hi_wr = 0; cnt_lo_wr = 1; cnt_byte = c[7:0];
    @(negedge clk);
    cnt_lo_wr = 0;
    pulse_set();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
  endtask

  // monitor: scoreboard of bytes leaving on the bus side
  always @(posedge clk) begin
    if (rst_ni && tx_valid && tx_ack) begin
      total++;
      tx_seen++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected byte act=%h exp=none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          bad++;
          $display("FAIL R6 byte order act=%h exp=%h", tx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_empty", host_empty, 1);
    chk("R1 alt_empty", alt_empty, 1);
    chk("R1 sel", sel, 0);
    chk("R1 done", done, 1);
    chk("R1 flags", {ovf, unf, arm_err}, 0);

    // R3/R10 fill FIFO 0 with four words (8 bytes)
    host_write(16'h2211, 1);
    host_write(16'h4433, 1);
    host_write(16'h6655, 1);
    host_write(16'h8877, 0);
    exp_q.push_back(8'h77);            // 0x88 is the pad byte of the odd count
    chk("R10 host_full", host_full, 1);
    chk("R10 alt_empty", alt_empty, 1);
    chk("R3 ovf before", ovf, 0);
    host_write(16'hAAAA, 0);
    chk("R3 ovf after dropped write", ovf, 1);
    chk("R3 still full", host_full, 1);

    // R2 flip
    pulse_flip();
    chk("R2 sel", sel, 1);
    chk("R2 host_empty", host_empty, 1);
    chk("R10 alt_full", alt_full, 1);

    // R5/R6 odd send of 7 bytes
    phase_in = 1; tx_ack = 1;
    load_count(16'd7);
    chk("R5 done low while running", done, 0);
    pulse_set();
    chk("R8 arm_err on busy set", arm_err, 1);
    wait_done();
    chk("R5 done after count", done, 1);
    chk("R5 bytes moved", tx_seen, 7);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    chk("R9 pad discarded", alt_empty, 1);
    chk("R6 no valid when idle", tx_valid, 0);

    // R8 zero count
    tx_ack = 0;
    load_count(16'd0);
    chk("R8 zero count keeps done", done, 1);

    // R7 receive 5 bytes
    phase_in = 0;
    chk("R7 no ready when idle", rx_ready, 0);
    load_count(16'd5);
    chk("R5 done low for receive", done, 0);
    begin
      int n = 0;
      while (n < 5) begin
        if (rx_ready) begin
          rx_valid = 1; rx_data = 8'hA1 + 8'(n); n++;
        end else rx_valid = 0;
        @(negedge clk);
      end
      rx_valid = 0;
    end
    chk("R5 receive done", done, 1);
    chk("R7 stored in alt", alt_empty, 0);
    chk("R7 ready drops", rx_ready, 0);

    // R2/R4 flip and read back
    pulse_flip();
    chk("R2 sel back", sel, 0);
    chk("R4 word0", host_rdata, 32'hA2A1);
    host_read();
    chk("R4 word1", host_rdata, 32'hA4A3);
    host_read();
    chk("R4 half word", host_rdata, 32'h00A5);
    host_read();
    chk("R10 empty after reads", host_empty, 1);
    chk("R4 unf before", unf, 0);
    host_read();
    chk("R4 unf after empty read", unf, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule